// File: doc/BRIEF.md
# Button-Stepped Four-Shape Waveform Generator

This block produces a continuous stream of 8-bit samples that trace one of four periodic shapes: sine, triangle, square or sawtooth. Each shape is held as a 64-point table. All four tables share one phase address, which moves forward by one point each time an internal sample strobe fires. A registered two-bit code picks which table drives the output. A one-bit control halves the amplitude by shifting the selected sample right by one place.

The output frequency is set by a step index from 0 to 40. Two button inputs move this index, and two force inputs jump it to either end of the range. Each step maps to a fixed integer clock divisor. A toggling divider counts system clocks up to that divisor, and every rising edge of its output advances the phase address. The same step also selects a five-digit BCD reading of the nominal frequency for an external display. Leading zero digits on that display are shown blank. The block assumes a 12 MHz system clock by default, and all divisors are derived from that clock frequency.

Top module: `wavegen_top`

## Requirements
- R1: While `rst_n` is low at a clock edge, the step index, the divider count and the phase address are cleared, and `sample` reads 0. After reset, `freq_bcd` shows 100 Hz as 20'hFF100.
- R2: Each level change on `btn_up` passes through two flip-flops and raises the step index by one. Index 40 wraps to 0. When both buttons change in the same cycle, the up change wins.
- R3: Each level change on `btn_dn` passes through two flip-flops and lowers the step index by one. Index 0 wraps to 40.
- R4: `force_max` sets the index to 40 and beats `force_min`. `force_min` sets the index to 0. Both beat button changes, and a button change that arrives while a force input is high is dropped.
- R5: The nominal frequency is 100 Hz at step 0 and 500·step Hz at every other step. `freq_bcd` carries five BCD digits, ten-thousands in bits [19:16] down to units in [3:0]. A zero digit with only zero digits above it reads 4'hF (blank). The units digit is never blanked.
- R6: The divisor is D = floor((CLK_HZ + 64·f)/(128·f)) − 1, with f the nominal frequency. This gives D = 937, 93, 8 and 4 at steps 0, 2, 20 and 40. In steady state a new sample appears every 2·(D+1) clocks.
- R7: When the divisor changes, the divider restarts its count from zero. The first new sample after a step change therefore arrives within 20 clocks when the new divisor is 4.
- R8: The phase address i advances by one per strobe and wraps from 63 to 0. The shapes are selected by code 0 to 3 as follows. Code 0 is sine: with q = {255,254,252,249,245,239,233,225,217,207,197,186,174,162,150,137}, s(i) = q[i] for i < 16, 255 − q[31−i] for 16 ≤ i < 32, and s(63−i) for i ≥ 32. Code 1 is triangle: 8·i for i < 32, 255 at i = 32, and 8·(64−i) above that. Code 2 is square: 255 for i < 32, otherwise 0. Code 3 is sawtooth: 4·i.
- R9: When `amp_half` is 1, `sample` is the table value shifted right by one, so it never exceeds 127. When `amp_half` is 0, `sample` is the full table value.
- R10: A change of `wave_sel` or `amp_half` shows at `sample` within two clocks. The phase address keeps running and is not reset by the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (nominal 12 MHz) |
| rst_n | input | 1 | Synchronous active-low reset |
| wave_sel | input | 2 | Shape code: 0 sine, 1 triangle, 2 square, 3 sawtooth |
| amp_half | input | 1 | 1 halves the output amplitude |
| btn_up | input | 1 | Frequency-up button; every level change is one step |
| btn_dn | input | 1 | Frequency-down button; every level change is one step |
| force_max | input | 1 | Jump to the highest step (priority) |
| force_min | input | 1 | Jump to the lowest step |
| sample | output | 8 | Current waveform sample |
| freq_bcd | output | 20 | Nominal frequency, five BCD digits, 4'hF = blank |

## Verification
The step logic is tested with runs of up and down toggles of different lengths. These runs cross both wrap points, so wrap errors can be told apart from simple off-by-one counts. The display reading after each run checks both the index and the digit blanking. Sample spacing is measured at four divisors, from 4 up to 937. This separates a correct 2·(D+1) cadence from a divider that is off by one count or by half a period. A step change made in the middle of a long count shows whether the divider restarts. All four shapes, plus the halved triangle, are read point by point after aligning to the sawtooth phase. This catches wrong table contents, a wrong selector mapping, and any address reset on a shape switch.

// File: rtl/wavegen_pkg.sv
// Shared constants and elaboration-time helpers for the waveform generator.
// Assumes the lowest nominal frequency is at step 0.
package wavegen_pkg;

    localparam int SAMPLE_W   = 8;
    localparam int TAB_DEPTH  = 64;
    localparam int ADDR_W     = $clog2(TAB_DEPTH);
    localparam int NUM_SHAPES = 4;
    localparam int BCD_W      = 20;
    localparam logic [3:0] DIGIT_BLANK = 4'hF;

    typedef enum logic [1:0] {
        SHAPE_SINE   = 2'd0,
        SHAPE_TRI    = 2'd1,
        SHAPE_SQUARE = 2'd2,
        SHAPE_SAW    = 2'd3
    } shape_e;

    // Nominal output frequency of a step in Hz.
    function automatic int step_freq(input int step, input int base_hz, input int inc_hz);
        return (step == 0) ? base_hz : inc_hz * step;
    endfunction

    // Toggle-divider terminal count for a given frequency (rounded).
    function automatic int step_divisor(input int freq, input int clk_hz);
        return (clk_hz + TAB_DEPTH * freq) / (2 * TAB_DEPTH * freq) - 1;
    endfunction

    // Five BCD digits of a frequency, leading zeros replaced by the blank code.
    function automatic logic [BCD_W-1:0] bcd_of_freq(input int freq);
        logic [BCD_W-1:0] res;
        int   scale;
        int   dig;
        bit   leading;
        res     = '0;
        scale   = 10000;
        leading = 1'b1;
        for (int d = 4; d >= 0; d--) begin
            dig = (freq / scale) % 10;
            if (leading && dig == 0 && d != 0) begin
                res[d*4 +: 4] = DIGIT_BLANK;
            end else begin
                res[d*4 +: 4] = 4'(dig);
                leading = 1'b0;
            end
            scale = scale / 10;
        end
        return res;
    endfunction

    // First quarter of the sine shape, peak at index 0.
    function automatic int sine_quarter(input int k);
        case (k)
            0: return 255;   1: return 254;   2: return 252;   3: return 249;
            4: return 245;   5: return 239;   6: return 233;   7: return 225;
            8: return 217;   9: return 207;  10: return 197;  11: return 186;
           12: return 174;  13: return 162;  14: return 150;  default: return 137;
        endcase
    endfunction

    // Table entry of one shape at one phase index.
    function automatic logic [SAMPLE_W-1:0] shape_value(input int shape, input int idx);
        int half;
        int j;
        int v;
        half = TAB_DEPTH / 2;
        case (shape)
            0: begin
                j = (idx < half) ? idx : (TAB_DEPTH - 1 - idx);
                v = (j < half / 2) ? sine_quarter(j) : 255 - sine_quarter(half - 1 - j);
            end
            1: v = (idx < half) ? 8 * idx : ((idx == half) ? 255 : 8 * (TAB_DEPTH - idx));
            2: v = (idx < half) ? 255 : 0;
            default: v = 4 * idx;
        endcase
        return SAMPLE_W'(v);
    endfunction

endpackage

// File: rtl/wg_step_ctrl.sv
// Step index control: synchronises both buttons through two flops, treats each
// level change as one step, and applies the force inputs with priority.
// Assumes the buttons are already debounced upstream.
module wg_step_ctrl #(
    parameter int MAX_STEP = 40,
    parameter int STEP_W   = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              btn_up,
    input  logic              btn_dn,
    input  logic              force_max,
    input  logic              force_min,
    output logic [STEP_W-1:0] step_idx
);

    localparam logic [STEP_W-1:0] TOP_STEP = STEP_W'(MAX_STEP);

    logic up_s0, up_s1, dn_s0, dn_s1;
    logic up_evt, dn_evt;

    // Two-flop chains for both buttons.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            up_s0 <= 1'b0;
            up_s1 <= 1'b0;
            dn_s0 <= 1'b0;
            dn_s1 <= 1'b0;
        end else begin
            up_s0 <= btn_up;
            up_s1 <= up_s0;
            dn_s0 <= btn_dn;
            dn_s1 <= dn_s0;
        end
    end

    // A difference across a chain marks one step event.
    always_comb begin
        up_evt = up_s0 ^ up_s1;
        dn_evt = dn_s0 ^ dn_s1;
    end

    // Step index update: force max, force min, up, down, in that priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_idx <= '0;
        end else if (force_max) begin
            step_idx <= TOP_STEP;
        end else if (force_min) begin
            step_idx <= '0;
        end else if (up_evt) begin
            step_idx <= (step_idx == TOP_STEP) ? '0 : step_idx + 1'b1;
        end else if (dn_evt) begin
            step_idx <= (step_idx == '0) ? TOP_STEP : step_idx - 1'b1;
        end
    end

endmodule

// File: rtl/wg_freq_map.sv
// Step-to-divisor and step-to-display lookup. Both tables are built at
// elaboration time from the clock and frequency parameters.
// Assumes every step index below NUM_STEPS; larger values map to step 0.
module wg_freq_map
    import wavegen_pkg::*;
#(
    parameter int CLK_HZ    = 12_000_000,
    parameter int BASE_HZ   = 100,
    parameter int INC_HZ    = 500,
    parameter int NUM_STEPS = 41,
    parameter int STEP_W    = 6,
    parameter int DIV_W     = 10
) (
    input  logic [STEP_W-1:0] step_idx,
    output logic [DIV_W-1:0]  divisor,
    output logic [BCD_W-1:0]  freq_bcd
);

    logic [DIV_W-1:0] div_tab [NUM_STEPS];
    logic [BCD_W-1:0] bcd_tab [NUM_STEPS];

    for (genvar g = 0; g < NUM_STEPS; g++) begin : g_step
        assign div_tab[g] = DIV_W'(step_divisor(step_freq(g, BASE_HZ, INC_HZ), CLK_HZ));
        assign bcd_tab[g] = bcd_of_freq(step_freq(g, BASE_HZ, INC_HZ));
    end

    // Select the entries of the current step.
    always_comb begin
        if (int'(step_idx) < NUM_STEPS) begin
            divisor  = div_tab[step_idx];
            freq_bcd = bcd_tab[step_idx];
        end else begin
            divisor  = div_tab[0];
            freq_bcd = bcd_tab[0];
        end
    end

endmodule

// File: rtl/wg_clk_div.sv
// Toggling divider: counts 0..divisor, then clears and toggles. A one-cycle
// advance strobe marks each rising toggle. Restarts when the divisor changes.
// Assumes the divisor is held stable between step changes.
module wg_clk_div #(
    parameter int DIV_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] divisor,
    output logic             adv
);

    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] div_q;
    logic             tog;

    // Count, toggle and strobe generation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            div_q <= divisor;
            tog   <= 1'b0;
            adv   <= 1'b0;
        end else if (divisor != div_q) begin
            div_q <= divisor;
            cnt   <= '0;
            adv   <= 1'b0;
        end else if (cnt >= div_q) begin
            cnt <= '0;
            tog <= ~tog;
            adv <= ~tog;
        end else begin
            cnt <= cnt + 1'b1;
            adv <= 1'b0;
        end
    end

endmodule

// File: rtl/wg_wave_rom.sv
// Four constant shape tables sharing one phase address, a registered 4-to-1
// selector and the halving stage. Address advances on each strobe.
// Assumes the strobe is a single-cycle pulse.
module wg_wave_rom
    import wavegen_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                adv,
    input  logic [1:0]          wave_sel,
    input  logic                amp_half,
    output logic [ADDR_W-1:0]   rom_addr,
    output logic                half_q,
    output logic [SAMPLE_W-1:0] sample
);

    logic [SAMPLE_W-1:0] tab [NUM_SHAPES][TAB_DEPTH];
    logic [1:0]          sel_q;
    logic [SAMPLE_W-1:0] picked;

    for (genvar gs = 0; gs < NUM_SHAPES; gs++) begin : g_shape
        for (genvar gi = 0; gi < TAB_DEPTH; gi++) begin : g_idx
            assign tab[gs][gi] = shape_value(gs, gi);
        end
    end

    // Shared phase address, wrapping naturally at the table depth.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rom_addr <= '0;
        end else if (adv) begin
            rom_addr <= rom_addr + 1'b1;
        end
    end

    // Register the shape code and amplitude control.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q  <= SHAPE_SINE;
            half_q <= 1'b0;
        end else begin
            sel_q  <= wave_sel;
            half_q <= amp_half;
        end
    end

    // Four-way selection of the current table entry.
    always_comb begin
        picked = tab[sel_q][rom_addr];
    end

    // Output sample register with optional halving.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sample <= '0;
        end else begin
            sample <= half_q ? (picked >> 1) : picked;
        end
    end

endmodule

// File: rtl/wavegen_top.sv
// Top of the waveform generator: step control, frequency lookup, divider and
// shape tables. Assumes a single clock domain; buttons are asynchronous.
module wavegen_top
    import wavegen_pkg::*;
#(
    parameter int CLK_HZ    = 12_000_000,
    parameter int BASE_HZ   = 100,
    parameter int INC_HZ    = 500,
    parameter int NUM_STEPS = 41
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          wave_sel,
    input  logic                amp_half,
    input  logic                btn_up,
    input  logic                btn_dn,
    input  logic                force_max,
    input  logic                force_min,
    output logic [SAMPLE_W-1:0] sample,
    output logic [BCD_W-1:0]    freq_bcd
);

    localparam int MAX_STEP = NUM_STEPS - 1;
    localparam int STEP_W   = $clog2(NUM_STEPS);
    localparam int MAX_DIV  = step_divisor(step_freq(0, BASE_HZ, INC_HZ), CLK_HZ);
    localparam int DIV_W    = $clog2(MAX_DIV + 1);

    logic [STEP_W-1:0] step_idx;
    logic [DIV_W-1:0]  divisor;
    logic              adv;
    logic [ADDR_W-1:0] rom_addr;
    logic              half_q;

    wg_step_ctrl #(
        .MAX_STEP(MAX_STEP),
        .STEP_W  (STEP_W)
    ) u_step (
        .clk      (clk),
        .rst_n    (rst_n),
        .btn_up   (btn_up),
        .btn_dn   (btn_dn),
        .force_max(force_max),
        .force_min(force_min),
        .step_idx (step_idx)
    );

    wg_freq_map #(
        .CLK_HZ   (CLK_HZ),
        .BASE_HZ  (BASE_HZ),
        .INC_HZ   (INC_HZ),
        .NUM_STEPS(NUM_STEPS),
        .STEP_W   (STEP_W),
        .DIV_W    (DIV_W)
    ) u_map (
        .step_idx(step_idx),
        .divisor (divisor),
        .freq_bcd(freq_bcd)
    );

    wg_clk_div #(
        .DIV_W(DIV_W)
    ) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .divisor(divisor),
        .adv    (adv)
    );

    wg_wave_rom u_rom (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv     (adv),
        .wave_sel(wave_sel),
        .amp_half(amp_half),
        .rom_addr(rom_addr),
        .half_q  (half_q),
        .sample  (sample)
    );

endmodule

// File: rtl/wg_checker.sv
// Property checker for the waveform generator, bound into the top module.
module wg_checker #(
    parameter int MAX_STEP = 40,
    parameter int STEP_W   = 6,
    parameter int ADDR_W   = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              force_max,
    input logic              force_min,
    input logic [STEP_W-1:0] step_idx,
    input logic              adv,
    input logic [ADDR_W-1:0] rom_addr,
    input logic              half_q,
    input logic [7:0]        sample,
    input logic [19:0]       freq_bcd
);

    assert_step_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        int'(step_idx) <= MAX_STEP);

    assert_force_max_R4: assert property (@(posedge clk) disable iff (!rst_n)
        force_max |=> int'(step_idx) == MAX_STEP);

    assert_force_min_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (force_min && !force_max) |=> step_idx == '0);

    assert_lead_digit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (freq_bcd[19:16] == 4'hF) || (freq_bcd[19:16] <= 4'd2));

    assert_addr_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> rom_addr == ADDR_W'($past(rom_addr) + 1'b1));

    assert_addr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(rom_addr));

    assert_half_peak_R9: assert property (@(posedge clk) disable iff (!rst_n)
        half_q |=> !sample[7]);

endmodule

bind wavegen_top wg_checker #(
    .MAX_STEP(MAX_STEP),
    .STEP_W  (STEP_W),
    .ADDR_W  (ADDR_W)
) u_wg_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .force_max(force_max),
    .force_min(force_min),
    .step_idx (step_idx),
    .adv      (adv),
    .rom_addr (rom_addr),
    .half_q   (half_q),
    .sample   (sample),
    .freq_bcd (freq_bcd)
);

// File: tb/tb_wavegen_top.sv
module tb_wavegen_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  wave_sel = 2'd0;
    logic        amp_half = 1'b0;
    logic        btn_up = 1'b0;
    logic        btn_dn = 1'b0;
    logic        force_max = 1'b0;
    logic        force_min = 1'b0;
    logic [7:0]  sample;
    logic [19:0] freq_bcd;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    wavegen_top dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .wave_sel (wave_sel),
        .amp_half (amp_half),
        .btn_up   (btn_up),
        .btn_dn   (btn_dn),
        .force_max(force_max),
        .force_min(force_min),
        .sample   (sample),
        .freq_bcd (freq_bcd)
    );

    // Stimulus vectors: {direction (1 = up), toggle count, expected step}.
    localparam int NVEC = 8;
    localparam logic [10:0] VEC [NVEC] = '{
        {1'b1, 4'd1,  6'd1},
        {1'b1, 4'd2,  6'd3},
        {1'b0, 4'd4,  6'd40},
        {1'b1, 4'd1,  6'd0},
        {1'b0, 4'd1,  6'd40},
        {1'b0, 4'd3,  6'd37},
        {1'b1, 4'd5,  6'd1},
        {1'b1, 4'd15, 6'd16}
    };

    function automatic int exp_freq(input int step);
        return (step == 0) ? 100 : 500 * step;
    endfunction

    function automatic int exp_div(input int step);
        int f;
        f = exp_freq(step);
        return (12_000_000 + 64 * f) / (128 * f) - 1;
    endfunction

    function automatic logic [19:0] exp_bcd(input int step);
        int f;
        int dv;
        logic [19:0] r;
        bit all_zero;
        f = exp_freq(step);
        all_zero = 1'b1;
        r = '0;
        dv = 10000;
        for (int d = 4; d >= 0; d--) begin
            int dg;
            dg = (f / dv) % 10;
            if (dg != 0 || d == 0) all_zero = 1'b0;
            r[d*4 +: 4] = all_zero ? 4'hF : 4'(dg);
            dv = dv / 10;
        end
        return r;
    endfunction

    function automatic int sine_q(input int k);
        int q [16] = '{255,254,252,249,245,239,233,225,217,207,197,186,174,162,150,137};
        return q[k];
    endfunction

    function automatic int exp_wave(input int w, input int i);
        int j;
        case (w)
            0: begin
                j = (i < 32) ? i : 63 - i;
                return (j < 16) ? sine_q(j) : 255 - sine_q(31 - j);
            end
            1: return (i < 32) ? 8 * i : ((i == 32) ? 255 : 8 * (64 - i));
            2: return (i < 32) ? 255 : 0;
            default: return 4 * i;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    task automatic wait_change(output int cycles);
        logic [7:0] prev;
        int c;
        prev = sample;
        c = 0;
        do begin
            @(negedge clk);
            c++;
        end while (sample == prev && c < 5000);
        cycles = c;
    endtask

    task automatic press(input bit up, input int n);
        for (int k = 0; k < n; k++) begin
            if (up) btn_up = ~btn_up;
            else    btn_dn = ~btn_dn;
            repeat (3) @(negedge clk);
        end
    endtask

    task automatic measure(input string req, input int step);
        int c;
        wave_sel = 2'd1;
        amp_half = 1'b0;
        wait_change(c);
        wait_change(c);
        wait_change(c);
        check(c == 2 * (exp_div(step) + 1), req, c, 2 * (exp_div(step) + 1));
    endtask

    // Align on the sawtooth phase, then switch shape and read 64 points.
    task automatic walk(input int w, input bit half, input string req);
        int c;
        int idx;
        wave_sel = 2'd3;
        amp_half = 1'b0;
        wait_change(c);
        wait_change(c);
        wait_change(c);
        idx = int'(sample) / 4;
        wave_sel = 2'(w);
        amp_half = half;
        repeat (5) @(negedge clk);
        for (int k = 0; k < 64; k++) begin
            int e;
            e = exp_wave(w, (idx + k) % 64) >> half;
            check(int'(sample) == e, req, int'(sample), e);
            repeat (10) @(negedge clk);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int c;
        repeat (4) @(negedge clk);
        // R1: reset state
        check(sample == 8'd0, "R1 sample", int'(sample), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(freq_bcd == 20'hFF100, "R1 display", int'(freq_bcd), 32'hFF100);

        // R6: spacing at step 0
        measure("R6 step0", 0);

        // R2 R3 R5: vector walk from step 0
        force_min = 1'b1;
        @(negedge clk);
        force_min = 1'b0;
        @(negedge clk);
        for (int v = 0; v < NVEC; v++) begin
            press(VEC[v][10], int'(VEC[v][9:6]));
            repeat (2) @(negedge clk);
            check(freq_bcd == exp_bcd(int'(VEC[v][5:0])),
                  VEC[v][10] ? "R2 R5 up" : "R3 R5 down",
                  int'(freq_bcd), int'(exp_bcd(int'(VEC[v][5:0]))));
        end

        // R2: both buttons in one cycle, up wins (16 -> 17)
        btn_up = ~btn_up;
        btn_dn = ~btn_dn;
        repeat (4) @(negedge clk);
        check(freq_bcd == exp_bcd(17), "R2 simultaneous", int'(freq_bcd), int'(exp_bcd(17)));
        press(1'b1, 3);
        repeat (2) @(negedge clk);
        check(freq_bcd == exp_bcd(20), "R5 step20", int'(freq_bcd), int'(exp_bcd(20)));
        measure("R6 step20", 20);

        // R6: step 2
        force_min = 1'b1;
        @(negedge clk);
        force_min = 1'b0;
        press(1'b1, 2);
        measure("R6 step2", 2);

        // R7: divisor change in the middle of a long count
        wave_sel = 2'd1;
        wait_change(c);
        repeat (60) @(negedge clk);
        force_max = 1'b1;
        @(negedge clk);
        force_max = 1'b0;
        wait_change(c);
        check(c + 1 <= 20, "R7 restart", c + 1, 20);
        measure("R6 step40", 40);

        // R8 R10: shapes point by point at step 40
        walk(0, 1'b0, "R8 R10 sine");
        walk(1, 1'b0, "R8 R10 triangle");
        walk(2, 1'b0, "R8 R10 square");
        walk(3, 1'b0, "R8 sawtooth");
        walk(1, 1'b1, "R9 R10 half triangle");
        walk(2, 1'b1, "R9 half square");

        // R4: force priority and dropped button changes
        force_max = 1'b1;
        force_min = 1'b1;
        repeat (2) @(negedge clk);
        check(freq_bcd == 20'h20000, "R4 max over min", int'(freq_bcd), 32'h20000);
        force_max = 1'b0;
        btn_up = ~btn_up;
        repeat (5) @(negedge clk);
        check(freq_bcd == 20'hFF100, "R4 min over button", int'(freq_bcd), 32'hFF100);
        force_min = 1'b0;
        repeat (4) @(negedge clk);
        check(freq_bcd == 20'hFF100, "R4 button dropped", int'(freq_bcd), 32'hFF100);

        // R1: reset during operation
        press(1'b0, 3);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check(sample == 8'd0, "R1 mid reset sample", int'(sample), 0);
        check(freq_bcd == 20'hFF100, "R1 mid reset display", int'(freq_bcd), 32'hFF100);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule